// File: doc/BRIEF.md
# Transmit Clock Source Supervisor

This block watches two slow clocks from a fast system clock and decides where the transmit clock of a line interface comes from. The first slow clock is the transmit clock input. The second is a fallback reference. The block detects when either clock is lost by counting periods in which no edge arrives. When automatic failover is enabled, a lost transmit clock input moves the transmit clock selection to the local oscillator output. One cycle later, the oscillator's reference selection moves from the transmit clock input to the fallback reference. When the input recovers, both selections return to it.

Software sees each change of either selection as a sticky, maskable status bit that drives one interrupt line. Turning automatic failover off always forces both selections back to the transmit clock input and sets both status bits again. Two live flags show the current loss state of each input. An oscillator centre/freeze control is passed through a register. The line mode (E1 or T1) picks the timeout for a missing period, because the two modes have different nominal rates.

Top module: `tx_clk_supervisor`

## Requirements
- R1: After synchronous reset, every output is 0: both selections point at the transmit clock input, both loss flags are clear, the sticky bits and the interrupt are clear, and the centre output is 0.
- R2: For each input, one to three consecutive missing periods do not set its loss flag (`tx_lost_o`, `fb_lost_o`). A fourth consecutive missing period sets it.
- R3: A period counts as missing when no rising edge arrives within a timeout of system clock cycles. The timeout is TMO_E1 (default 73) when `mode_t1_i`=0 and TMO_T1 (default 97) when `mode_t1_i`=1.
- R4: A set loss flag clears on the GOOD_LIMIT-th (default 8) consecutive rising edge. A missing period restarts this count.
- R5: With `auto_en_i`=1, a set `tx_lost_o` drives `tx_sel_o` to 1 (oscillator output). When the loss clears, `tx_sel_o` returns to 0 (transmit clock input).
- R6: With `auto_en_i`=1 and `tx_sel_o`=1, a lost transmit clock input sets `ref_sel_o` to 1 (fallback reference) one cycle after `tx_sel_o` changes. `ref_sel_o` returns to 0 when the loss clears. `ref_sel_o` is 1 only while `tx_sel_o` is 1.
- R7: A change of `tx_sel_o` sets `sticky_o[0]`. A change of `ref_sel_o` sets `sticky_o[1]`. Both changes appear on the same clock edge.
- R8: While `auto_en_i`=0, both selections are 0 whether or not the input is lost. The edge where `auto_en_i` goes from 1 to 0 sets both sticky bits.
- R9: A one-cycle `clr_sticky_i` clears both sticky bits. An event in the same cycle as the clear leaves its bit set.
- R10: `irq_o` is 1 exactly when some sticky bit is set and its `mask_i` bit is 0. A mask bit of 1 blocks that bit.
- R11: `centre_o` follows `centre_i` with one cycle of delay.
- R12: Loss of the fallback reference only sets `fb_lost_o`. It does not change either selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_t1_i | input | 1 | 0 = E1 timeout, 1 = T1 timeout |
| auto_en_i | input | 1 | Automatic failover enable |
| txclk_i | input | 1 | Transmit clock input (asynchronous) |
| fbclk_i | input | 1 | Fallback reference clock (asynchronous) |
| clr_sticky_i | input | 1 | One-cycle clear strobe for the sticky bits |
| mask_i | input | 2 | Interrupt mask per sticky bit, 1 blocks |
| centre_i | input | 1 | Oscillator centre/freeze request |
| tx_sel_o | output | 1 | Transmit clock select: 0 input, 1 oscillator |
| ref_sel_o | output | 1 | Oscillator reference select: 0 transmit input, 1 fallback |
| tx_lost_o | output | 1 | Transmit clock input currently lost |
| fb_lost_o | output | 1 | Fallback reference currently lost |
| sticky_o | output | 2 | Sticky events: bit 0 transmit select, bit 1 reference select |
| irq_o | output | 1 | Interrupt request |
| centre_o | output | 1 | Registered centre/freeze control |

## Verification
The loss detector is driven with a steady clock, with short pauses that leave out two or three periods, and with long stops. This separates tolerated gaps from a declared loss and shows the restart of the good-edge count. The same long pause is repeated in both line modes, which tells the E1 timeout from the T1 timeout. The transmit input is stopped and restarted with failover on, with failover off, and with failover switched while the input is lost. This shows the order of the two selections, the forced return, and the sticky bits under different masks. A clear strobe given in the same cycle as a forced-return event checks that the event wins.

// File: rtl/tx_clksup_pkg.sv
package tx_clksup_pkg;

    typedef enum logic {
        SRC_TXIN = 1'b0,
        SRC_OSC  = 1'b1
    } tx_src_e;

    typedef enum logic {
        REF_TXIN     = 1'b0,
        REF_FALLBACK = 1'b1
    } osc_ref_e;

    typedef enum logic {
        MODE_E1 = 1'b0,
        MODE_T1 = 1'b1
    } line_mode_e;

    localparam int unsigned EV_TXSEL = 0;
    localparam int unsigned EV_REF   = 1;
    localparam int unsigned EV_N     = 2;

    typedef struct packed {
        tx_src_e  tx;
        osc_ref_e rf;
    } sel_state_t;

    function automatic int unsigned nominal_tmo(line_mode_e m,
                                                int unsigned e1,
                                                int unsigned t1);
        return (m == MODE_T1) ? t1 : e1;
    endfunction

endpackage

// File: rtl/clk_loss_mon.sv
module clk_loss_mon #(
    parameter int unsigned TMO_W      = 8,
    parameter int unsigned MISS_LIMIT = 4,
    parameter int unsigned GOOD_LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_in,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             lost_o
);
    localparam int unsigned MISS_W = $clog2(MISS_LIMIT + 1);
    localparam int unsigned GOOD_W = $clog2(GOOD_LIMIT + 1);

    logic [2:0]        sh_q;
    logic              rise;
    logic [TMO_W-1:0]  gap_q;
    logic              timeout;
    logic [MISS_W-1:0] miss_q;
    logic [GOOD_W-1:0] good_q;
    logic              lost_q;

    assign rise    = sh_q[1] & ~sh_q[2];
    assign timeout = !rise && (gap_q == tmo_i - TMO_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            gap_q  <= '0;
            miss_q <= '0;
            good_q <= '0;
            lost_q <= 1'b0;
        end else begin
            sh_q <= {sh_q[1:0], clk_in};

            if (rise || timeout) gap_q <= '0;
            else                 gap_q <= gap_q + TMO_W'(1);

            if (rise)
                miss_q <= '0;
            else if (timeout && miss_q != MISS_W'(MISS_LIMIT))
                miss_q <= miss_q + MISS_W'(1);

            if (!lost_q || timeout)
                good_q <= '0;
            else if (rise)
                good_q <= (good_q == GOOD_W'(GOOD_LIMIT - 1)) ? '0 : good_q + GOOD_W'(1);

            if (!lost_q && timeout && miss_q == MISS_W'(MISS_LIMIT - 1))
                lost_q <= 1'b1;
            else if (lost_q && rise && good_q == GOOD_W'(GOOD_LIMIT - 1))
                lost_q <= 1'b0;
        end
    end

    assign lost_o = lost_q;

    // R2
    loss_on_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_q) |-> !$past(rise));

    // R4
    clear_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lost_q) |-> $past(rise));

endmodule

// File: rtl/src_select.sv
module src_select
    import tx_clksup_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            auto_en_i,
    input  logic            tx_lost_i,
    output sel_state_t      sel_o,
    output logic [EV_N-1:0] ev_o
);
    logic       auto_q;
    logic       auto_fall;
    sel_state_t sel_q;
    sel_state_t sel_nxt;

    assign auto_fall = auto_q & ~auto_en_i;

    always_comb begin
        sel_nxt.tx = (auto_en_i && tx_lost_i) ? SRC_OSC : SRC_TXIN;
        sel_nxt.rf = (auto_en_i && tx_lost_i && sel_q.tx == SRC_OSC)
                     ? REF_FALLBACK : REF_TXIN;
        ev_o[EV_TXSEL] = (sel_nxt.tx != sel_q.tx) | auto_fall;
        ev_o[EV_REF]   = (sel_nxt.rf != sel_q.rf) | auto_fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_q <= 1'b0;
            sel_q  <= '{tx: SRC_TXIN, rf: REF_TXIN};
        end else begin
            auto_q <= auto_en_i;
            sel_q  <= sel_nxt;
        end
    end

    assign sel_o = sel_q;

    // R8
    force_back_chk: assert property (@(posedge clk) disable iff (rst)
        !auto_en_i |=> (sel_q.tx == SRC_TXIN && sel_q.rf == REF_TXIN));

    // R6
    ref_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_q.rf == REF_FALLBACK) |-> (sel_q.tx == SRC_OSC));

endmodule

// File: rtl/event_status.sv
module event_status
    import tx_clksup_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [EV_N-1:0] ev_i,
    input  logic            clr_i,
    input  logic [EV_N-1:0] mask_i,
    output logic [EV_N-1:0] sticky_o,
    output logic            irq_o
);
    logic [EV_N-1:0] sticky_q;

    for (genvar b = 0; b < EV_N; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)        sticky_q[b] <= 1'b0;
            else if (ev_i[b]) sticky_q[b] <= 1'b1;
            else if (clr_i) sticky_q[b] <= 1'b0;
        end

        // R7
        event_sets_chk: assert property (@(posedge clk) disable iff (rst)
            ev_i[b] |=> sticky_q[b]);

        // R9
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (sticky_q[b] && !clr_i) |=> sticky_q[b]);
    end

    assign sticky_o = sticky_q;
    assign irq_o    = |(sticky_q & ~mask_i);

endmodule

// File: rtl/tx_clk_supervisor.sv
module tx_clk_supervisor
    import tx_clksup_pkg::*;
#(
    parameter int unsigned TMO_E1     = 73,
    parameter int unsigned TMO_T1     = 97,
    parameter int unsigned MISS_LIMIT = 4,
    parameter int unsigned GOOD_LIMIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_t1_i,
    input  logic       auto_en_i,
    input  logic       txclk_i,
    input  logic       fbclk_i,
    input  logic       clr_sticky_i,
    input  logic [1:0] mask_i,
    input  logic       centre_i,
    output logic       tx_sel_o,
    output logic       ref_sel_o,
    output logic       tx_lost_o,
    output logic       fb_lost_o,
    output logic [1:0] sticky_o,
    output logic       irq_o,
    output logic       centre_o
);
    localparam int unsigned TMO_MAX = (TMO_E1 > TMO_T1) ? TMO_E1 : TMO_T1;
    localparam int unsigned TMO_W   = $clog2(TMO_MAX + 1);

    line_mode_e      mode;
    logic [TMO_W-1:0] tmo;
    logic [1:0]      clk_vec;
    logic [1:0]      lost_vec;
    sel_state_t      sel;
    logic [EV_N-1:0] ev;
    logic            centre_q;

    assign mode    = line_mode_e'(mode_t1_i);
    assign tmo     = TMO_W'(nominal_tmo(mode, TMO_E1, TMO_T1));
    assign clk_vec = {fbclk_i, txclk_i};

    for (genvar i = 0; i < 2; i++) begin : g_mon
        clk_loss_mon #(
            .TMO_W      (TMO_W),
            .MISS_LIMIT (MISS_LIMIT),
            .GOOD_LIMIT (GOOD_LIMIT)
        ) u_mon (
            .clk    (clk),
            .rst    (rst),
            .clk_in (clk_vec[i]),
            .tmo_i  (tmo),
            .lost_o (lost_vec[i])
        );
    end

    src_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .auto_en_i (auto_en_i),
        .tx_lost_i (lost_vec[0]),
        .sel_o     (sel),
        .ev_o      (ev)
    );

    event_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .ev_i     (ev),
        .clr_i    (clr_sticky_i),
        .mask_i   (mask_i),
        .sticky_o (sticky_o),
        .irq_o    (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) centre_q <= 1'b0;
        else     centre_q <= centre_i;
    end

    assign tx_sel_o  = sel.tx;
    assign ref_sel_o = sel.rf;
    assign tx_lost_o = lost_vec[0];
    assign fb_lost_o = lost_vec[1];
    assign centre_o  = centre_q;

    // R11
    centre_delay_chk: assert property (@(posedge clk) disable iff (rst)
        $past(centre_i) == centre_o);

    // R12
    fb_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (!lost_vec[0] && $past(!lost_vec[0])) |-> (sel.tx == SRC_TXIN));

endmodule

// File: tb/test_tx_clk_supervisor.sv
module test_tx_clk_supervisor;

    localparam int HALF = 24;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_t1_i, auto_en_i, txclk_i, fbclk_i, clr_sticky_i, centre_i;
    logic [1:0] mask_i;
    logic       tx_sel_o, ref_sel_o, tx_lost_o, fb_lost_o, irq_o, centre_o;
    logic [1:0] sticky_o;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    logic tx_run, fb_run;
    int  tx_cnt, fb_cnt;

    typedef struct {
        string      req;
        logic [7:0] exp;
    } item_t;
    item_t sb_q[$];
    event  chk_ev;

    always #5 clk = ~clk;

    tx_clk_supervisor i_tx_clk_supervisor (
        .clk(clk), .rst(rst), .mode_t1_i(mode_t1_i), .auto_en_i(auto_en_i),
        .txclk_i(txclk_i), .fbclk_i(fbclk_i), .clr_sticky_i(clr_sticky_i),
        .mask_i(mask_i), .centre_i(centre_i), .tx_sel_o(tx_sel_o),
        .ref_sel_o(ref_sel_o), .tx_lost_o(tx_lost_o), .fb_lost_o(fb_lost_o),
        .sticky_o(sticky_o), .irq_o(irq_o), .centre_o(centre_o)
    );

    always @(negedge clk) begin
        if (!tx_run) begin txclk_i <= 1'b0; tx_cnt <= 0; end
        else if (tx_cnt == HALF - 1) begin txclk_i <= ~txclk_i; tx_cnt <= 0; end
        else tx_cnt <= tx_cnt + 1;
        if (!fb_run) begin fbclk_i <= 1'b0; fb_cnt <= 0; end
        else if (fb_cnt == HALF - 1) begin fbclk_i <= ~fbclk_i; fb_cnt <= 0; end
        else fb_cnt <= fb_cnt + 1;
    end

    // packing: {irq, sticky1, sticky0, fb_lost, tx_lost, ref_sel, tx_sel, centre}
    function automatic logic [7:0] pk(logic irq, logic [1:0] st, logic fbl,
                                      logic txl, logic rs, logic ts, logic ce);
        return {irq, st, fbl, txl, rs, ts, ce};
    endfunction

    initial begin : monitor
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = pk(irq_o, sticky_o, fb_lost_o, tx_lost_o, ref_sel_o, tx_sel_o, centre_o);
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%b expected=%b", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic expect_state(string req, logic [7:0] exp);
        item_t it;
        it.req = req;
        it.exp = exp;
        sb_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pause_fb(int n, output logic seen);
        seen = 1'b0;
        fb_run = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (fb_lost_o) seen = 1'b1;
        end
        fb_run = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (fb_lost_o) seen = 1'b1;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        logic seen;
        rst = 1'b1; mode_t1_i = 1'b0; auto_en_i = 1'b1; clr_sticky_i = 1'b0;
        mask_i = 2'b00; centre_i = 1'b0; tx_run = 1'b1; fb_run = 1'b1;
        txclk_i = 1'b0; fbclk_i = 1'b0;
        wait_n(6);
        rst = 1'b0;
        @(negedge clk);
        expect_state("R1 reset", pk(0, 2'b00, 0, 0, 0, 0, 0));

        wait_n(800);
        expect_state("R2 steady clocks", pk(0, 2'b00, 0, 0, 0, 0, 0));

        // R2: short gap, two missing periods
        pause_fb(120, seen);
        check_bit("R2 short gap tolerated", seen, 1'b0);

        // R3: gap giving three T1 timeouts but four E1 timeouts
        mode_t1_i = 1'b1;
        wait_n(200);
        pause_fb(290, seen);
        check_bit("R3 T1 timeout no loss", seen, 1'b0);
        mode_t1_i = 1'b0;
        wait_n(200);
        pause_fb(290, seen);
        check_bit("R3 E1 timeout loss", seen, 1'b1);
        wait_n(700);
        check_bit("R4 fallback recovered", fb_lost_o, 1'b0);

        // R12: fallback loss leaves selections untouched
        fb_run = 1'b0;
        wait_n(600);
        expect_state("R12 fallback lost only", pk(0, 2'b00, 1, 0, 0, 0, 0));
        fb_run = 1'b1;
        wait_n(HALF * 2 * 3);
        check_bit("R4 not cleared after few edges", fb_lost_o, 1'b1);
        wait_n(500);
        check_bit("R4 cleared after good edges", fb_lost_o, 1'b0);

        // R5 R6 R7: transmit input lost with failover
        tx_run = 1'b0;
        wait_n(600);
        expect_state("R5 R6 R7 failover", pk(1, 2'b11, 0, 1, 1, 1, 0));
        clr_sticky_i = 1'b1; @(negedge clk); clr_sticky_i = 1'b0;
        expect_state("R9 clear", pk(0, 2'b00, 0, 1, 1, 1, 0));

        // R10: recovery with both bits masked
        mask_i = 2'b11;
        tx_run = 1'b1;
        wait_n(700);
        expect_state("R5 R10 recovered masked", pk(0, 2'b11, 0, 0, 0, 0, 0));
        mask_i = 2'b01;
        @(negedge clk);
        expect_state("R10 bit1 unmasked", pk(1, 2'b11, 0, 0, 0, 0, 0));
        mask_i = 2'b00;

        // R8: failover disabled, forced event on falling enable
        auto_en_i = 1'b0;
        wait_n(2);
        clr_sticky_i = 1'b1; @(negedge clk); clr_sticky_i = 1'b0;
        tx_run = 1'b0;
        wait_n(600);
        expect_state("R8 no auto while lost", pk(0, 2'b00, 0, 1, 0, 0, 0));
        auto_en_i = 1'b1;
        @(negedge clk);
        expect_state("R5 R7 tx sel first", pk(1, 2'b01, 0, 1, 0, 1, 0));
        @(negedge clk);
        expect_state("R6 R7 ref follows", pk(1, 2'b11, 0, 1, 1, 1, 0));
        clr_sticky_i = 1'b1; @(negedge clk); clr_sticky_i = 1'b0;
        expect_state("R9 clear again", pk(0, 2'b00, 0, 1, 1, 1, 0));
        auto_en_i = 1'b0;
        clr_sticky_i = 1'b1;
        @(negedge clk);
        clr_sticky_i = 1'b0;
        expect_state("R8 R9 forced back event wins", pk(1, 2'b11, 0, 1, 0, 0, 0));
        tx_run = 1'b1;
        auto_en_i = 1'b1;
        wait_n(700);
        clr_sticky_i = 1'b1; @(negedge clk); clr_sticky_i = 1'b0;

        // R11
        centre_i = 1'b1;
        @(negedge clk);
        expect_state("R11 centre delayed", pk(0, 2'b00, 0, 0, 0, 0, 1));
        centre_i = 1'b0;
        @(negedge clk);
        check_bit("R11 centre low", centre_o, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule